// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a memory-mapped watchdog. A 16-bit up-counter advances once per tick of a selectable power-of-two prescaler. Software loads the counter with 65536 minus the wanted number of ticks and sets the enable bit. If software does not reload the counter first, the count passes 0xFFFF. The block then raises a one-cycle reset request and latches a sticky overflow flag. Reloading the counter while it runs is the keep-alive.

Every write must carry a fixed key pattern in its upper bits, and each register has its own key. A write with any other upper pattern changes nothing. A busy flag shows that a recent accepted write is still being carried into the prescaled domain. The flag stays up for two prescaled ticks, and software polls it clear before it enables the timer.

There are two reset inputs. The power-on reset clears everything. The system reset is the one the watchdog itself causes. It clears all state except the overflow flag, so software can still read the cause of the last reset after the reset is over. The register port is a plain one-cycle write strobe with a combinational read. It has no handshake and never stalls.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset, offsets 0, 4 and 8 all read 0 and reset_req is low.
- R2: A write to offset 0 is accepted only when wdata[31:16] is 0x5A5A. A write to offset 4 or 8 is accepted only when wdata[31:8] is 0xA5A5A5. Any other write leaves every register and the busy flag unchanged.
- R3: Register layout and read-back:
  - Offset 0 returns the counter in bits 15:0.
  - Offset 4 returns the control/status byte: enable in bit 7, busy in bit 5 (read-only), overflow in bit 4, divider select in bits 2:0.
  - Offset 8 is an 8-bit read/write byte.
  - Bits 6 and 3 of offset 4, all other upper bits, and all other offsets read 0.
- R4: While enable is 1, the counter rises by exactly one on each prescaled tick. While enable is 0, it holds its value.
- R5: Divider select 0 to 7 gives tick periods of 1, 4, 16, 32, 64, 128, 1024 and 4096 clocks. A write that changes the enable bit or the divider restarts the prescaler. The first tick then lands exactly one full period after the write edge.
- R6: Overflow on a single edge:
  - A tick at count 0xFFFF wraps the count to 0, sets the overflow flag, and makes reset_req high for exactly one clock.
  - Starting from load value L, with period P and the enabling write at edge W, this happens at edge W + P*(65536-L).
- R7: An accepted counter write while running reloads the count. The overflow then moves to the write edge plus P*(65536-L), and no earlier reset_req pulse occurs.
- R8: Any accepted write sets busy for two prescaled ticks. With period 1 it reads 1 for exactly two clocks after the write edge. With period 16, after a write that restarts the prescaler, it clears 32 clocks after the write edge.
- R9: The overflow flag is cleared only in two ways: an accepted offset-4 write with bit 4 at 0, or power-on reset. Writing 1 to bit 4 leaves the flag as it is, and system reset keeps it.
- R10: System reset clears the counter, enable, divider, the offset-8 byte and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous, keeps the overflow flag |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data, key in the upper bits |
| rdata | output | 32 | Read data for addr, combinational |
| reset_req | output | 1 | One-clock reset request on overflow |

## Verification
Register writes become visible on the clock edge that samples them, and reads are combinational. The bench therefore reads back at the falling edge that follows each write edge. The first count lands P clocks after an enabling write. Busy drops two ticks after the write, and reset_req is due exactly P*(65536-L) clocks after the enabling write or the last reload. The bench writes each of these due cycles into a queue at stimulus time. A monitor compares every reset_req pulse against the front of that queue, so a pulse that comes early, late or unannounced is reported. Edge counts for timed register reads are taken from a free-running cycle counter and sampled at falling edges.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int NUM_DIV    = 8;
  localparam int SEL_W      = $clog2(NUM_DIV);
  localparam int PRE_W      = 12;
  localparam int BUSY_TICKS = 2;
  localparam int REG_W      = 8;

  localparam int OFS_CNT = 0;
  localparam int OFS_CSA = 4;
  localparam int OFS_CSB = 8;

  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;

  localparam int BIT_EN   = 7;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OVF  = 4;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // log2 of the tick period for each divider select value
  function automatic int div_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      6:       return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
  import keyed_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] taps;

  // free-running count; restarted when divider or enable changes (R5)
  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    localparam int SH = div_shift(i);
    if (SH == 0) begin : g_every
      assign taps[i] = 1'b1;
    end else begin : g_mask
      assign taps[i] = &pre_q[SH-1:0];
    end
  end

  assign tick = taps[sel] & ~restart;
endmodule

// File: rtl/kwd_busy.sv
module kwd_busy #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int W = $clog2(DEPTH + 1);
  logic [W-1:0] left_q;

  // R8: busy for DEPTH prescaled ticks after an accepted write
  always_ff @(posedge clk) begin
    if (!rst_n)                    left_q <= '0;
    else if (load)                 left_q <= W'(DEPTH);
    else if (tick && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             reset_req
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic step;

  assign step    = en & tick & ~load;
  assign ovf_evt = step && (cnt == TOP);

  // R4/R6/R7: load has priority over counting; wrap raises a one-cycle request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= ovf_evt;
      if (load)      cnt <= load_val;
      else if (step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              busy,
  input  logic              ovf_evt,
  output ctl_t              ctl,
  output logic              ovf,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              acc_wr,
  output logic              restart,
  output logic [DATA_W-1:0] rdata
);
  localparam int KCNT_LSB = DATA_W - 16;
  localparam int KCTL_LSB = DATA_W - 24;

  logic key_cnt_ok, key_ctl_ok;
  logic acc_cnt, acc_csa, acc_csb;
  ctl_t new_ctl;
  logic [REG_W-1:0] csb_q;
  logic [REG_W-1:0] csa_view;

  // R2: per-register keys
  assign key_cnt_ok = (wdata[DATA_W-1:KCNT_LSB] == KEY_CNT);
  assign key_ctl_ok = (wdata[DATA_W-1:KCTL_LSB] == KEY_CTL);
  assign acc_cnt = wr_en && (addr == ADDR_W'(OFS_CNT)) && key_cnt_ok;
  assign acc_csa = wr_en && (addr == ADDR_W'(OFS_CSA)) && key_ctl_ok;
  assign acc_csb = wr_en && (addr == ADDR_W'(OFS_CSB)) && key_ctl_ok;
  assign acc_wr  = acc_cnt | acc_csa | acc_csb;

  assign cnt_load = acc_cnt;
  assign cnt_val  = wdata[CNT_W-1:0];

  assign new_ctl.en  = wdata[BIT_EN];
  assign new_ctl.sel = wdata[SEL_W-1:0];
  assign restart     = acc_csa && (new_ctl != ctl);

  always_ff @(posedge clk) begin
    if (!por_n || !sys_rst_n) begin
      ctl   <= '0;
      csb_q <= '0;
    end else begin
      if (acc_csa) ctl   <= new_ctl;
      if (acc_csb) csb_q <= wdata[REG_W-1:0];
    end
  end

  // R9: sticky flag survives system reset
  always_ff @(posedge clk) begin
    if (!por_n)                         ovf <= 1'b0;
    else if (ovf_evt)                   ovf <= 1'b1;
    else if (acc_csa && !wdata[BIT_OVF]) ovf <= 1'b0;
  end

  always_comb begin
    csa_view              = '0;
    csa_view[SEL_W-1:0]   = ctl.sel;
    csa_view[BIT_OVF]     = ovf;
    csa_view[BIT_BUSY]    = busy;
    csa_view[BIT_EN]      = ctl.en;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_CNT): rdata[CNT_W-1:0] = cnt;
      ADDR_W'(OFS_CSA): rdata[REG_W-1:0] = csa_view;
      ADDR_W'(OFS_CSB): rdata[REG_W-1:0] = csb_q;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              reset_req
);
  logic             run_n;
  ctl_t             ctl;
  logic             ctrl_en;
  logic             ovf_q;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_wr;
  logic             restart;
  logic             tick;
  logic             busy;
  logic             ovf_evt;

  assign run_n   = por_n & sys_rst_n;
  assign ctrl_en = ctl.en;

  kwd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .cnt(cnt_q), .busy(busy), .ovf_evt(ovf_evt),
    .ctl(ctl), .ovf(ovf_q), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .acc_wr(acc_wr), .restart(restart), .rdata(rdata)
  );

  kwd_prescaler pre_i (
    .clk(clk), .rst_n(run_n), .restart(restart), .sel(ctl.sel), .tick(tick)
  );

  kwd_busy #(.DEPTH(BUSY_TICKS)) busy_i (
    .clk(clk), .rst_n(run_n), .load(acc_wr), .tick(tick), .busy(busy)
  );

  kwd_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(run_n), .en(ctrl_en), .tick(tick), .load(cnt_load),
    .load_val(cnt_val), .cnt(cnt_q), .ovf_evt(ovf_evt), .reset_req(reset_req)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              reset_req,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              ovf,
  input logic              busy
);
  logic run_n, at_cnt, at_csa, at_ctl, cnt_key, ctl_key, good_any, bad_cnt;

  assign run_n    = por_n && sys_rst_n;
  assign at_cnt   = wr_en && (addr == ADDR_W'(OFS_CNT));
  assign at_csa   = wr_en && (addr == ADDR_W'(OFS_CSA));
  assign at_ctl   = at_csa || (wr_en && (addr == ADDR_W'(OFS_CSB)));
  assign cnt_key  = (wdata[DATA_W-1:DATA_W-16] == KEY_CNT);
  assign ctl_key  = (wdata[DATA_W-1:DATA_W-24] == KEY_CTL);
  assign good_any = (at_cnt && cnt_key) || (at_ctl && ctl_key);
  assign bad_cnt  = at_cnt && !cnt_key;

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!run_n)
    reset_req |=> !reset_req);

  assert_req_flags_R6: assert property (@(posedge clk) disable iff (!run_n)
    reset_req |-> (ovf && cnt == '0));

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!run_n)
    (bad_cnt && !en) |=> $stable(cnt));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!run_n)
    (!en && !at_cnt) |=> $stable(cnt));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!run_n)
    (en && !at_cnt) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!run_n)
    good_any |=> busy);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    (ovf && !at_csa) |=> ovf);
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .reset_req(reset_req), .cnt(cnt_q),
  .en(ctrl_en), .ovf(ovf_q), .busy(busy)
);

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  keyed_wdog dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] kc(input logic [15:0] v);
    return {16'h5A5A, v};
  endfunction
  function automatic logic [31:0] ka(input logic [7:0] v);
    return {24'hA5A5A5, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_req(input int c);
    exp_q.push_back(c);
  endtask

  // scoreboard monitor for reset_req pulses (R6, R7)
  always @(negedge clk) begin
    if (por_n && sys_rst_n && reset_req) begin
      int e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected reset_req actual=%0d expected=none", cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6/R7 reset_req cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, k;
    int shifts[8] = '{0, 2, 4, 5, 6, 7, 10, 12};
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 cnt", 4'd0, 32'h0);
    rdchk("R1 csa", 4'd4, 32'h0);
    rdchk("R1 csb", 4'd8, 32'h0);
    chk("R1 reset_req", {31'b0, reset_req}, 32'h0);

    // R3 layout
    wr(4'd8, ka(8'h5C));
    rdchk("R3 csb readback", 4'd8, 32'h5C);
    rdchk("R3 unmapped offset", 4'd12, 32'h0);
    wr(4'd4, ka(8'h48)); w = cyc;
    wait_to(w + 3);
    rdchk("R3 reserved csa bits", 4'd4, 32'h0);

    // R2 keys
    wr(4'd0, {16'h5A5B, 16'h1234});
    rdchk("R2 bad cnt key", 4'd0, 32'h0);
    rdchk("R2 bad key no busy", 4'd4, 32'h0);
    wr(4'd4, {24'hA5A5A4, 8'h87});
    rdchk("R2 bad csa key", 4'd4, 32'h0);
    wr(4'd8, {24'hA4A5A5, 8'hFF});
    rdchk("R2 bad csb key", 4'd8, 32'h5C);
    wr(4'd8, {16'h5A5A, 16'h00FF});
    rdchk("R2 cnt key on csb", 4'd8, 32'h5C);
    wr(4'd0, ka(8'h11));
    rdchk("R2 ctl key on cnt", 4'd0, 32'h0);

    // R8 busy with period 1
    wr(4'd0, kc(16'h1000)); w = cyc;
    rdchk("R2 good cnt key", 4'd0, 32'h1000);
    rdchk("R8 busy edge+0", 4'd4, 32'h20);
    wait_to(w + 1);
    rdchk("R8 busy edge+1", 4'd4, 32'h20);
    wait_to(w + 2);
    rdchk("R8 busy clear edge+2", 4'd4, 32'h00);

    // R8 busy with period 16 after restart
    wr(4'd4, ka(8'h02)); w = cyc;
    wait_to(w + 31);
    rdchk("R8 busy p16 edge+31", 4'd4, 32'h22);
    wait_to(w + 32);
    rdchk("R8 busy p16 edge+32", 4'd4, 32'h02);

    // R5 first tick for each divider
    for (int i = 0; i < 8; i++) begin
      int p;
      p = 1 << shifts[i];
      wr(4'd0, kc(16'h0000));
      wr(4'd4, ka(8'h80 | 8'(i))); w = cyc;
      if (p > 1) begin
        wait_to(w + p - 1);
        rdchk($sformatf("R5 div%0d before tick", i), 4'd0, 32'h0);
      end
      wait_to(w + p);
      rdchk($sformatf("R5 div%0d first tick", i), 4'd0, 32'h1);
      wr(4'd4, ka(8'(i)));
    end

    // R4 counting and hold
    wr(4'd0, kc(16'h1000));
    wr(4'd4, ka(8'h80)); w = cyc;
    wait_to(w + 5);
    rdchk("R4 count +5", 4'd0, 32'h1005);
    wait_to(w + 9);
    rdchk("R4 count +9", 4'd0, 32'h1009);
    wr(4'd4, ka(8'h00)); k = cyc;
    rdchk("R4 value at stop", 4'd0, 32'h1000 + 32'(k - w - 1));
    wait_to(k + 10);
    rdchk("R4 hold while disabled", 4'd0, 32'h1000 + 32'(k - w - 1));

    // R6 overflow, period 1
    wr(4'd0, kc(16'hFFF0));
    wr(4'd4, ka(8'h80)); w = cyc;
    expect_req(w + 16);
    wait_to(w + 17);
    rdchk("R6 ovf flag p1", 4'd4, 32'h90);
    rdchk("R6 wrapped count", 4'd0, 32'h1);

    // R9 clear rules
    wr(4'd4, ka(8'h10)); w = cyc;
    wait_to(w + 3);
    rdchk("R9 write 1 keeps ovf", 4'd4, 32'h10);
    wr(4'd4, ka(8'h00)); w = cyc;
    wait_to(w + 3);
    rdchk("R9 write 0 clears ovf", 4'd4, 32'h00);

    // R6 overflow, period 4
    wr(4'd0, kc(16'hFFFC));
    wr(4'd4, ka(8'h81)); w = cyc;
    expect_req(w + 16);
    wait_to(w + 20);
    rdchk("R6 ovf flag p4", 4'd4, 32'h91);

    // R10 system reset keeps ovf (R9), clears the rest
    wr(4'd8, ka(8'h3C));
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); sys_rst_n = 1'b1;
    rdchk("R9 ovf kept by sys reset", 4'd4, 32'h10);
    rdchk("R10 cnt cleared", 4'd0, 32'h0);
    rdchk("R10 csb cleared", 4'd8, 32'h0);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    rdchk("R9 por clears ovf", 4'd4, 32'h0);

    // R7 keep-alive reload
    wr(4'd0, kc(16'hFFF0));
    wr(4'd4, ka(8'h80)); w = cyc;
    wait_to(w + 10);
    wr(4'd0, kc(16'hFFF0)); k = cyc;
    expect_req(k + 16);
    wait_to(k + 20);
    rdchk("R7 ovf after reload", 4'd4, 32'h90);
    wr(4'd4, ka(8'h00));
    repeat (4) @(negedge clk);
    chk("R6/R7 all pulses seen", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule